// File: doc/BRIEF.md
# Programmable Pulse Generator

This block produces timed pulse trains from a down counter and three programmable values: a cycle value, a duty value and a start delay. Each count tick decrements the counter. The output is low while the count is above the duty value. It rises when the count reaches the duty value and stays high until the counter passes zero. That underflow (the borrow) reloads the counter from the cycle value. A period therefore lasts cycle+1 ticks, and the output is high for duty+1 of them.

The tick comes from an internal prescaler running on the block clock, or from an external underflow strobe supplied by a neighbouring reload timer. A generator starts on a software strobe or on a hardware trigger input, and it can wait a programmed number of ticks before it loads its first period. It runs in one of two ways:
- Continuous PWM: it repeats periods until it is halted.
- One-shot: it stops after its first borrow and stays stopped until it is re-armed.

The generator reports one-cycle event strobes for an accepted start, a borrow and a duty match. It also drives a converter-start strobe taken from one of two events of channel 0. A split mode turns the counter into two independent half-width generators.

Top module: `pulse_gen`

## Requirements
- R1: With extSel low, one tick occurs every N clocks, where divSel 0, 1, 2 and 3 select N = 1, 4, 16 and 64. In steady PWM the output period is (cycle+1)*N clocks.
- R2: With extSel high, each one-clock pulse on extTick is one tick, and the prescaler is not used.
- R3: In PWM the output is high for (duty+1) ticks of every (cycle+1)-tick period, and it rises at the duty match. When duty >= cycle the output stays high continuously while running.
- R4: An idle channel starts on swTrig, or on hwTrig when the matching hwTrigEn bit is set. A hwTrig pulse while hwTrigEn is low starts nothing.
- R5: Let L be the start delay. With divide 1 and L > 0, the output first rises L + cycle - duty clock edges after the edge that accepts the start. With L = 0 it rises cycle - duty edges after that edge.
- R6: In one-shot mode a start gives exactly one pulse of duty+1 ticks, and the output then stays low. Further starts are ignored until a rearm pulse. In either mode, rearm returns the channel to idle with its output low.
- R7: New cycle and duty values take effect only at the next borrow. A pulse already in progress keeps the duty value it started with.
- R8: With splitMode high, channel 0 uses bits [7:0] and channel 1 uses bits [15:8] of cycleVal, dutyVal and delayVal. The two channels run independently, each with its own trigger, rearm and one-shot bit. With splitMode low, channel 0 uses the full 16 bits, and channel 1 stays idle with its output and strobes low.
- R9: irqTrig[c] is high for one clock right after the edge that accepts a start. irqBorrow[c] and irqDuty[c] each pulse once per period.
- R10: adcTrig repeats the channel 0 duty-match strobe when adcOnDuty is 1, and the channel 0 borrow strobe when adcOnDuty is 0.
- R11: After reset all outputs are low and both channels are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| splitMode | input | 1 | 1: two half-width channels; 0: one full-width channel |
| oneShot | input | 2 | Per channel: 1 selects one-shot, 0 selects PWM |
| divSel | input | 2 | Prescaler select: 0=/1, 1=/4, 2=/16, 3=/64 |
| extSel | input | 1 | 1: tick on extTick instead of the prescaler |
| extTick | input | 1 | External underflow strobe |
| swTrig | input | 2 | Per-channel software start strobe |
| hwTrig | input | 1 | Hardware start strobe, shared by both channels |
| hwTrigEn | input | 2 | Per-channel enable for hwTrig |
| rearm | input | 2 | Per-channel halt and re-arm strobe |
| cycleVal | input | 16 | Cycle value (halves per channel in split mode) |
| dutyVal | input | 16 | Duty value |
| delayVal | input | 16 | Start delay in ticks |
| adcOnDuty | input | 1 | adcTrig source: 1 duty match, 0 borrow |
| pulseOut | output | 2 | Per-channel pulse output |
| irqTrig | output | 2 | Start-accepted strobe |
| irqBorrow | output | 2 | Borrow strobe |
| irqDuty | output | 2 | Duty-match strobe |
| adcTrig | output | 1 | Converter-start strobe |

## Verification
A counter that loses or gains a count appears at pulseOut within a single period, as a period or high time that is off by a multiple of the tick divisor. A wrongly latched duty value appears the same way, so measuring from one rising edge to the next catches both. A stuck channel state shows within one period as well: a one-shot that refires, a halted channel that still toggles, or a channel 1 that moves in full-width mode. A delay counter that is off by one shifts the first rising edge by exactly one tick. Each of these faults is tied to a cycle-exact expected value.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_RUN,
    ST_DONE
  } chState_e;

  // control -> datapath, one bit per channel
  typedef struct packed {
    logic [1:0] cntLoad;
    logic [1:0] cntDec;
    logic [1:0] dlyLoad;
    logic [1:0] dlyDec;
  } pgStrobe_t;

  // datapath -> control, one bit per channel
  typedef struct packed {
    logic [1:0] cntZero;
    logic [1:0] dlyLast;
    logic [1:0] dlyNone;
  } pgStatus_t;

endpackage

// File: rtl/pgen_prescaler.sv
module pgen_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             extSel,
  input  logic             extTick,
  output logic             tick
);
  // each select step multiplies the divisor by four
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < 2 * int'(divSel)) mask[i] = 1'b1;
    end
    tick = extSel ? extTick : ((preCnt & mask) == mask);
  end

endmodule

// File: rtl/pgen_control.sv
module pgen_control import pgen_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      splitMode,
  input  logic      tick,
  input  logic [1:0] swTrig,
  input  logic      hwTrig,
  input  logic [1:0] hwTrigEn,
  input  logic [1:0] oneShot,
  input  logic [1:0] rearm,
  input  pgStatus_t status,
  output pgStrobe_t strobe,
  output logic [1:0] running,
  output logic [1:0] irqTrig,
  output logic [1:0] irqBorrow
);

  generate
    for (genvar c = 0; c < 2; c++) begin : g_ch
      chState_e state, stateNxt;
      logic active, trigReq, accept;
      logic ldS, decS, dLdS, dDecS, brwS;
      logic trigQ, brwQ;

      assign active  = (c == 0) || splitMode;
      assign trigReq = swTrig[c] | (hwTrig & hwTrigEn[c]);

      always_comb begin
        stateNxt = state;
        ldS = 1'b0; decS = 1'b0; dLdS = 1'b0; dDecS = 1'b0; brwS = 1'b0;
        accept = 1'b0;
        unique case (state)
          ST_IDLE: begin
            if (trigReq) begin
              accept = 1'b1;
              if (status.dlyNone[c]) begin
                ldS = 1'b1;
                stateNxt = ST_RUN;
              end else begin
                dLdS = 1'b1;
                stateNxt = ST_DELAY;
              end
            end
          end
          ST_DELAY: begin
            if (tick) begin
              if (status.dlyLast[c]) begin
                ldS = 1'b1;
                stateNxt = ST_RUN;
              end else begin
                dDecS = 1'b1;
              end
            end
          end
          ST_RUN: begin
            if (tick) begin
              if (status.cntZero[c]) begin
                brwS = 1'b1;
                if (oneShot[c]) stateNxt = ST_DONE;
                else            ldS = 1'b1;
              end else begin
                decS = 1'b1;
              end
            end
          end
          ST_DONE: ;
        endcase
        // halt / re-arm, or channel unused in full-width mode
        if (rearm[c] || !active) begin
          stateNxt = ST_IDLE;
          ldS = 1'b0; decS = 1'b0; dLdS = 1'b0; dDecS = 1'b0; brwS = 1'b0;
          accept = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          state <= ST_IDLE;
          trigQ <= 1'b0;
          brwQ  <= 1'b0;
        end else begin
          state <= stateNxt;
          trigQ <= accept;
          brwQ  <= brwS;
        end
      end
    end
  endgenerate

  assign strobe.cntLoad = {g_ch[1].ldS,   g_ch[0].ldS};
  assign strobe.cntDec  = {g_ch[1].decS,  g_ch[0].decS};
  assign strobe.dlyLoad = {g_ch[1].dLdS,  g_ch[0].dLdS};
  assign strobe.dlyDec  = {g_ch[1].dDecS, g_ch[0].dDecS};
  assign running   = {g_ch[1].state == ST_RUN, g_ch[0].state == ST_RUN};
  assign irqTrig   = {g_ch[1].trigQ, g_ch[0].trigQ};
  assign irqBorrow = {g_ch[1].brwQ,  g_ch[0].brwQ};

endmodule

// File: rtl/pgen_datapath.sv
module pgen_datapath import pgen_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             splitMode,
  input  logic [CNT_W-1:0] cycleVal,
  input  logic [CNT_W-1:0] dutyVal,
  input  logic [CNT_W-1:0] delayVal,
  input  pgStrobe_t        strobe,
  input  logic [1:0]       running,
  output pgStatus_t        status,
  output logic [1:0]       waveOut,
  output logic [1:0]       dutyHit
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt, dutyAct, dly;
  logic [CNT_W-1:0] cntNxt, dutyNxt, dlyNxt;
  logic [1:0]       hitNxt;

  // value seen by channel c, zero-extended to full width
  function automatic logic [CNT_W-1:0] chView(input logic [CNT_W-1:0] v,
                                              input int c, input logic sp);
    if (!sp) return (c == 0) ? v : '0;
    return CNT_W'(v[c*HALF_W +: HALF_W]);
  endfunction

  // write channel c's value back into the shared vector
  function automatic logic [CNT_W-1:0] chPut(input logic [CNT_W-1:0] orig,
                                             input logic [CNT_W-1:0] v,
                                             input int c, input logic sp);
    logic [CNT_W-1:0] r;
    r = orig;
    if (sp)          r[c*HALF_W +: HALF_W] = v[HALF_W-1:0];
    else if (c == 0) r = v;
    return r;
  endfunction

  always_comb begin
    cntNxt  = cnt;
    dutyNxt = dutyAct;
    dlyNxt  = dly;
    hitNxt  = '0;
    for (int c = 0; c < 2; c++) begin
      logic [CNT_W-1:0] curCnt, curDuty, curDly, cycIn, dutyIn;
      logic [CNT_W-1:0] newCnt, newDuty, newDly;
      curCnt  = chView(cnt, c, splitMode);
      curDuty = chView(dutyAct, c, splitMode);
      curDly  = chView(dly, c, splitMode);
      cycIn   = chView(cycleVal, c, splitMode);
      dutyIn  = chView(dutyVal, c, splitMode);
      newCnt  = curCnt;
      newDuty = curDuty;
      newDly  = curDly;
      if (strobe.cntLoad[c]) begin
        newCnt    = cycIn;
        newDuty   = dutyIn;
        hitNxt[c] = (cycIn == dutyIn);
      end else if (strobe.cntDec[c]) begin
        newCnt    = curCnt - CNT_W'(1);
        hitNxt[c] = (newCnt == curDuty);
      end
      if (strobe.dlyLoad[c])     newDly = chView(delayVal, c, splitMode);
      else if (strobe.dlyDec[c]) newDly = curDly - CNT_W'(1);
      cntNxt  = chPut(cntNxt, newCnt, c, splitMode);
      dutyNxt = chPut(dutyNxt, newDuty, c, splitMode);
      dlyNxt  = chPut(dlyNxt, newDly, c, splitMode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dutyAct <= '0;
      dly     <= '0;
      dutyHit <= '0;
    end else begin
      cnt     <= cntNxt;
      dutyAct <= dutyNxt;
      dly     <= dlyNxt;
      dutyHit <= hitNxt;
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      status.cntZero[c] = (chView(cnt, c, splitMode) == '0);
      status.dlyLast[c] = (chView(dly, c, splitMode) == CNT_W'(1));
      status.dlyNone[c] = (chView(delayVal, c, splitMode) == '0);
      waveOut[c] = running[c] &&
                   (chView(cnt, c, splitMode) <= chView(dutyAct, c, splitMode));
    end
  end

endmodule

// File: rtl/pulse_gen.sv
module pulse_gen import pgen_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             splitMode,
  input  logic [1:0]       oneShot,
  input  logic [SEL_W-1:0] divSel,
  input  logic             extSel,
  input  logic             extTick,
  input  logic [1:0]       swTrig,
  input  logic             hwTrig,
  input  logic [1:0]       hwTrigEn,
  input  logic [1:0]       rearm,
  input  logic [CNT_W-1:0] cycleVal,
  input  logic [CNT_W-1:0] dutyVal,
  input  logic [CNT_W-1:0] delayVal,
  input  logic             adcOnDuty,
  output logic [1:0]       pulseOut,
  output logic [1:0]       irqTrig,
  output logic [1:0]       irqBorrow,
  output logic [1:0]       irqDuty,
  output logic             adcTrig
);
  logic       tick;
  pgStrobe_t  strobe;
  pgStatus_t  status;
  logic [1:0] running;

  pgen_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rstN(rstN), .divSel(divSel), .extSel(extSel),
    .extTick(extTick), .tick(tick)
  );

  pgen_control u_ctl (
    .clk(clk), .rstN(rstN), .splitMode(splitMode), .tick(tick),
    .swTrig(swTrig), .hwTrig(hwTrig), .hwTrigEn(hwTrigEn),
    .oneShot(oneShot), .rearm(rearm), .status(status), .strobe(strobe),
    .running(running), .irqTrig(irqTrig), .irqBorrow(irqBorrow)
  );

  pgen_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .splitMode(splitMode), .cycleVal(cycleVal),
    .dutyVal(dutyVal), .delayVal(delayVal), .strobe(strobe),
    .running(running), .status(status), .waveOut(pulseOut),
    .dutyHit(irqDuty)
  );

  assign adcTrig = adcOnDuty ? irqDuty[0] : irqBorrow[0];

endmodule

// File: rtl/pulse_gen_checker.sv
module pulse_gen_checker (
  input logic       clk,
  input logic       rstN,
  input logic       splitMode,
  input logic [1:0] oneShot,
  input logic       adcOnDuty,
  input logic [1:0] pulseOut,
  input logic [1:0] irqTrig,
  input logic [1:0] irqBorrow,
  input logic [1:0] irqDuty,
  input logic       adcTrig
);

  // R9: an accepted start leaves idle, so its strobe never repeats next cycle
  p_trig_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqTrig[0] |=> !irqTrig[0]);

  // R3: a duty match always coincides with a high output
  p_duty_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqDuty[0] |-> pulseOut[0]);

  // R6: a one-shot borrow leaves the output low
  p_oneshot_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqBorrow[0] && $past(oneShot[0])) |-> !pulseOut[0]);

  // R8: channel 1 stays silent in full-width mode
  p_split_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!splitMode && $past(!splitMode)) |-> (!pulseOut[1] && !irqTrig[1] && !irqDuty[1]));

  // R10: converter strobe on duty match only while the output is high
  p_adc_duty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (adcOnDuty && adcTrig) |-> pulseOut[0]);

endmodule

bind pulse_gen pulse_gen_checker u_chk (.*);

// File: tb/pulse_gen_tb.sv
`timescale 1ns/1ps
module pulse_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        splitMode = 1'b0;
  logic [1:0]  oneShot = '0;
  logic [1:0]  divSel = '0;
  logic        extSel = 1'b0;
  logic        extTick = 1'b0;
  logic [1:0]  swTrig = '0;
  logic        hwTrig = 1'b0;
  logic [1:0]  hwTrigEn = '0;
  logic [1:0]  rearm = '0;
  logic [15:0] cycleVal = '0;
  logic [15:0] dutyVal = '0;
  logic [15:0] delayVal = '0;
  logic        adcOnDuty = 1'b0;
  logic [1:0]  pulseOut, irqTrig, irqBorrow, irqDuty;
  logic        adcTrig;
  bit          extRun = 1'b0;
  int          nRun = 0;
  int          nFail = 0;

  pulse_gen u_dut (.*);

  always #10 clk = ~clk;

  function automatic int divOf(input int sel);
    return 1 << (2 * sel);
  endfunction
  function automatic int expPer(input int cyc, input int n);
    return (cyc + 1) * n;
  endfunction
  function automatic int expHi(input int duty, input int n);
    return (duty + 1) * n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic halt();
    @(negedge clk); rearm = 2'b11;
    @(negedge clk); rearm = 2'b00;
  endtask

  task automatic kick(input logic [1:0] m);
    @(negedge clk); swTrig = m;
    @(negedge clk); swTrig = 2'b00;
  endtask

  task automatic waitRise(input int c, output bit ok);
    logic prev;
    prev = pulseOut[c];
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!prev && pulseOut[c]) begin ok = 1'b1; return; end
      prev = pulseOut[c];
    end
  endtask

  task automatic measure(input int c, output int per, output int hi);
    bit ok;
    per = 0; hi = 0;
    waitRise(c, ok);
    if (!ok) return;
    hi = 1;
    for (int i = 0; i < 20000; i++) begin
      logic prev;
      prev = pulseOut[c];
      @(negedge clk);
      per++;
      if (!prev && pulseOut[c]) return;
      if (pulseOut[c]) hi++;
    end
  endtask

  // samples now, then n-1 more falling edges
  task automatic window(input int c, input int n, output int hi, output int tr,
                        output int br, output int dt, output int adc, output int adcMis);
    hi = 0; tr = 0; br = 0; dt = 0; adc = 0; adcMis = 0;
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge clk);
      hi  += int'(pulseOut[c]);
      tr  += int'(irqTrig[c]);
      br  += int'(irqBorrow[c]);
      dt  += int'(irqDuty[c]);
      adc += int'(adcTrig);
      if (adcTrig !== (adcOnDuty ? irqDuty[0] : irqBorrow[0])) adcMis++;
    end
  endtask

  // external underflow strobe: one pulse every third clock
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (extRun) begin
        ph = (ph + 1) % 3;
        extTick = (ph == 0);
      end else begin
        extTick = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int per, hi, tr, br, dt, adc, mis, n, cyc, duty, sel;
    bit ok;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 pulseOut", int'(pulseOut), 0);
    check("R11 strobes", int'({irqTrig, irqBorrow, irqDuty, adcTrig}), 0);

    // R3 full-width period above 8 bits
    cycleVal = 16'd300; dutyVal = 16'd100;
    kick(2'b01);
    measure(0, per, hi);
    check("R3 period 16b", per, 301);
    check("R3 high 16b", hi, 101);

    // R1 divide by 4
    halt();
    cycleVal = 16'd9; dutyVal = 16'd4; divSel = 2'd1;
    kick(2'b01);
    measure(0, per, hi);
    check("R1 period div4", per, expPer(9, 4));
    check("R1 high div4", hi, expHi(4, 4));

    // R1 divide by 64
    halt();
    cycleVal = 16'd3; dutyVal = 16'd1; divSel = 2'd3;
    kick(2'b01);
    measure(0, per, hi);
    check("R1 period div64", per, expPer(3, 64));
    check("R1 high div64", hi, expHi(1, 64));

    // R1 R3 constrained random
    for (int k = 0; k < 6; k++) begin
      halt();
      cyc  = int'($urandom_range(40, 2));
      duty = int'($urandom_range(cyc - 1, 0));
      sel  = int'($urandom_range(2, 0));
      cycleVal = 16'(cyc); dutyVal = 16'(duty); divSel = 2'(sel);
      kick(2'b01);
      measure(0, per, hi);
      check("R1 random period", per, expPer(cyc, divOf(sel)));
      check("R3 random high", hi, expHi(duty, divOf(sel)));
    end

    // R3 duty above cycle: constant high
    halt();
    divSel = 2'd0; cycleVal = 16'd5; dutyVal = 16'd7;
    kick(2'b01);
    window(0, 30, hi, tr, br, dt, adc, mis);
    check("R3 duty>=cycle high", hi, 30);

    // R5 start delay
    halt();
    cycleVal = 16'd10; dutyVal = 16'd3; delayVal = 16'd5;
    kick(2'b01);
    check("R9 irqTrig after start", int'(irqTrig[0]), 1);
    n = 0;
    while (!pulseOut[0] && n < 1000) begin @(negedge clk); n++; end
    check("R5 delay 5", n, 5 + 10 - 3);
    halt();
    delayVal = 16'd0;
    kick(2'b01);
    n = 0;
    while (!pulseOut[0] && n < 1000) begin @(negedge clk); n++; end
    check("R5 delay 0", n, 10 - 3);

    // R4 hardware trigger gating
    halt();
    @(negedge clk); hwTrig = 1'b1;
    @(negedge clk); hwTrig = 1'b0;
    window(0, 20, hi, tr, br, dt, adc, mis);
    check("R4 disabled hw trigger", hi + tr, 0);
    hwTrigEn = 2'b01;
    @(negedge clk); hwTrig = 1'b1;
    @(negedge clk); hwTrig = 1'b0;
    window(0, 20, hi, tr, br, dt, adc, mis);
    check("R4 enabled hw trigger", tr, 1);
    hwTrigEn = 2'b00;

    // R6 one-shot
    halt();
    oneShot = 2'b01; cycleVal = 16'd6; dutyVal = 16'd2;
    kick(2'b01);
    window(0, 40, hi, tr, br, dt, adc, mis);
    check("R6 one-shot high", hi, 3);
    check("R6 one-shot borrows", br, 1);
    kick(2'b01);
    window(0, 40, hi, tr, br, dt, adc, mis);
    check("R6 trigger ignored", hi + tr, 0);
    halt();
    kick(2'b01);
    window(0, 40, hi, tr, br, dt, adc, mis);
    check("R6 re-armed pulse", hi, 3);
    oneShot = 2'b00;
    halt();
    kick(2'b01);
    repeat (30) @(negedge clk);
    halt();
    window(0, 50, hi, tr, br, dt, adc, mis);
    check("R6 rearm stops PWM", hi, 0);

    // R7 update at next borrow
    cycleVal = 16'd20; dutyVal = 16'd5;
    kick(2'b01);
    waitRise(0, ok);
    cycleVal = 16'd30; dutyVal = 16'd15;
    hi = 1;
    while (hi < 1000) begin
      @(negedge clk);
      if (pulseOut[0]) hi++; else break;
    end
    check("R7 current pulse keeps duty", hi, 6);
    measure(0, per, hi);
    check("R7 new period", per, 31);
    check("R7 new high", hi, 16);

    // R9 R10 strobes
    halt();
    cycleVal = 16'd9; dutyVal = 16'd3; adcOnDuty = 1'b0;
    kick(2'b01);
    waitRise(0, ok);
    window(0, 50, hi, tr, br, dt, adc, mis);
    check("R9 borrow per period", br, 5);
    check("R9 duty per period", dt, 5);
    check("R10 adc follows borrow", mis, 0);
    adcOnDuty = 1'b1;
    window(0, 50, hi, tr, br, dt, adc, mis);
    check("R10 adc follows duty", mis, 0);
    check("R10 adc count", adc, 5);

    // R2 external tick
    halt();
    extSel = 1'b1; extRun = 1'b1;
    cycleVal = 16'd4; dutyVal = 16'd1;
    kick(2'b01);
    measure(0, per, hi);
    check("R2 ext period", per, 15);
    check("R2 ext high", hi, 6);
    halt();
    extSel = 1'b0; extRun = 1'b0;

    // R8 split mode
    splitMode = 1'b1;
    cycleVal = {8'd9, 8'd5}; dutyVal = {8'd3, 8'd1}; delayVal = 16'd0;
    kick(2'b11);
    measure(0, per, hi);
    check("R8 ch0 period", per, 6);
    check("R8 ch0 high", hi, 2);
    measure(1, per, hi);
    check("R8 ch1 period", per, 10);
    check("R8 ch1 high", hi, 4);
    @(negedge clk); rearm = 2'b10;
    @(negedge clk); rearm = 2'b00;
    measure(0, per, hi);
    check("R8 ch0 independent", per, 6);
    window(1, 30, hi, tr, br, dt, adc, mis);
    check("R8 ch1 halted", hi, 0);
    halt();
    splitMode = 1'b0;
    kick(2'b10);
    window(1, 30, hi, tr, br, dt, adc, mis);
    check("R8 ch1 idle in 16-bit", hi + tr + br + dt, 0);
    check("R8 ch0 unaffected", int'(pulseOut[0]), 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule